// File: doc/BRIEF.md
# Address-Pattern Memory Self-Test Engine

This engine tests a byte-addressed external memory through a simple request/acknowledge port. After a start strobe it divides the memory into 8-byte blocks and fills every block with a pattern derived from that block's own address. It then waits for a settle interval, reads every block back in short bursts and compares the data with the pattern. Any block that does not match counts as one error.

When the run ends, the engine raises `done`. It reports a pass flag, a saturating count of failing blocks and the address of the first failing block. Each block's pattern holds the bitwise inverse of the block address in the first four bytes and the plain address in the last four. Because of this, stuck, shorted or aliased address lines produce mismatches.

Top module: `addr_pattern_bist`

## Requirements
- R1: While reset is asserted and right after it, `done`, `pass`, `err_count`, `first_fail_addr` and `mem_req_valid` are all 0.
- R2: The write pass issues exactly one write per block, with length 8, at addresses 0, 8, 16 and so on in rising order. `mem_wdata[63:56]` is the byte at the lowest address. The 64-bit word is {~A, A}, where A is the block address zero-extended to 32 bits.
- R3: The tested region is `mem_size` rounded down to a multiple of 8, latched at start. Bytes beyond it are never accessed. A size below 8 produces no accesses and a pass.
- R4: Every write is acknowledged before the first read is issued. At least SETTLE_CYCLES clock cycles separate the last write acknowledge from the first read acknowledge.
- R5: Each read has length RD_BYTES (4). Read addresses step by RD_BYTES from 0 through the tested region. `mem_rdata[31:24]` is the byte at the request address.
- R6: A block with one or more wrong bytes adds exactly one to `err_count`.
- R7: `err_count` saturates at its all-ones value instead of wrapping.
- R8: `pass` is 1 exactly when `done` is 1 and `err_count` is 0.
- R9: `first_fail_addr` holds the address of the first block, in scan order, that failed. It stays 0 when no block fails.
- R10: An issued request keeps `mem_req_valid`, its address and its direction stable until `mem_ack` is seen.
- R11: `start` is ignored while a run is in progress. A `start` in the idle or done state begins a new run and clears the previous results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a test run (idle/done only) |
| mem_size | input | ADDR_W | Memory size in bytes, latched at start |
| mem_req_valid | output | 1 | Request pending |
| mem_req_write | output | 1 | 1 = write, 0 = read |
| mem_req_addr | output | ADDR_W | First byte address of the burst |
| mem_req_len | output | 5 | Burst length in bytes |
| mem_wdata | output | 64 | Write bytes, lowest address in the top byte |
| mem_ack | input | 1 | Completes the pending request; read data valid with it |
| mem_rdata | input | RD_BYTES*8 | Read bytes, lowest address in the top byte |
| done | output | 1 | Run finished |
| pass | output | 1 | Run finished with no failing block |
| err_count | output | ERR_W | Saturating count of failing blocks |
| first_fail_addr | output | ADDR_W | Block address of the first failure |

## Verification
A request appears combinationally in the cycle after the state register or the block address changes. The next request follows one clock edge after each acknowledge. The bench's responder answers one cycle after it sees a request. Its monitor therefore checks burst contents and order on the acknowledge edge itself, and it checks the settle gap as a cycle difference between the last write acknowledge and the first read acknowledge. The error count, pass flag and failing address are registered. They are final on the edge that enters the done state, so the bench samples them on the falling edge once `done` reads 1.

// File: rtl/addr_pattern_bist.sv
module addr_pattern_bist #(
  parameter int ADDR_W        = 32,
  parameter int ERR_W         = 16,
  parameter int RD_BYTES      = 4,
  parameter int SETTLE_CYCLES = 10_000_000
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start,
  input  logic [ADDR_W-1:0]       mem_size,
  output logic                    mem_req_valid,
  output logic                    mem_req_write,
  output logic [ADDR_W-1:0]       mem_req_addr,
  output logic [4:0]              mem_req_len,
  output logic [63:0]             mem_wdata,
  input  logic                    mem_ack,
  input  logic [RD_BYTES*8-1:0]   mem_rdata,
  output logic                    done,
  output logic                    pass,
  output logic [ERR_W-1:0]        err_count,
  output logic [ADDR_W-1:0]       first_fail_addr
);
  localparam int RDW   = RD_BYTES * 8;
  localparam int RD_N  = 8 / RD_BYTES;
  localparam int SUB_W = (RD_N > 1) ? $clog2(RD_N) : 1;
  localparam int CNT_W = $clog2(SETTLE_CYCLES + 1);
  localparam logic [ERR_W-1:0] ERR_MAX = {ERR_W{1'b1}};

  typedef enum logic [2:0] {S_IDLE, S_WR, S_SETTLE, S_RD, S_DONE} st_t;

  st_t               st;
  logic [ADDR_W-1:0] blk, end_q, ffa_q;
  logic [SUB_W-1:0]  sub;
  logic [CNT_W-1:0]  cnt;
  logic              bad_q;
  logic [ERR_W-1:0]  err_q;
  logic [31:0]       a32;
  logic [63:0]       pat;
  logic [RDW-1:0]    exp_chunk;
  logic              busy, at_end, last_sub, miss;

  assign busy      = (st == S_WR) || (st == S_SETTLE) || (st == S_RD);
  assign at_end    = (blk == end_q);
  assign last_sub  = (sub == SUB_W'(RD_N - 1));
  assign a32       = 32'(blk);
  assign pat       = {~a32, a32};
  assign exp_chunk = pat[63 - RDW*int'(sub) -: RDW];
  assign miss      = (mem_rdata != exp_chunk);

  assign mem_req_valid = ((st == S_WR) || (st == S_RD)) && !at_end;
  assign mem_req_write = (st == S_WR);
  assign mem_req_addr  = (st == S_RD) ? blk + ADDR_W'(int'(sub) * RD_BYTES) : blk;
  assign mem_req_len   = (st == S_WR) ? 5'd8 : 5'(RD_BYTES);
  assign mem_wdata     = pat;

  assign done            = (st == S_DONE);
  assign pass            = done && (err_q == '0);
  assign err_count       = err_q;
  assign first_fail_addr = ffa_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st    <= S_IDLE;
      blk   <= '0;
      end_q <= '0;
      sub   <= '0;
      cnt   <= '0;
      bad_q <= 1'b0;
      err_q <= '0;
      ffa_q <= '0;
    end else begin
      case (st)
        S_IDLE, S_DONE: if (start) begin
          st    <= S_WR;
          blk   <= '0;
          end_q <= mem_size & ~ADDR_W'(7);
          sub   <= '0;
          bad_q <= 1'b0;
          err_q <= '0;
          ffa_q <= '0;
        end
        S_WR: begin
          if (at_end) begin
            st  <= S_SETTLE;
            cnt <= '0;
          end else if (mem_ack) begin
            blk <= blk + ADDR_W'(8);
          end
        end
        S_SETTLE: begin
          if (cnt >= CNT_W'(SETTLE_CYCLES - 1)) begin
            st  <= S_RD;
            blk <= '0;
            sub <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        S_RD: begin
          if (at_end) begin
            st <= S_DONE;
          end else if (mem_ack) begin
            if (last_sub) begin
              sub   <= '0;
              bad_q <= 1'b0;
              blk   <= blk + ADDR_W'(8);
              if (bad_q || miss) begin
                if (err_q != ERR_MAX) err_q <= err_q + 1'b1;
                if (err_q == '0) ffa_q <= blk;
              end
            end else begin
              sub   <= sub + 1'b1;
              bad_q <= bad_q || miss;
            end
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  // R10
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_ack |=> mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_write));

  // R3
  req_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> mem_req_addr < end_q);

  // R6
  err_monotonic_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> err_q >= $past(err_q));

  // R7
  err_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && err_q == ERR_MAX |=> err_q == ERR_MAX);

  // R11
  done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done && !start |=> done && $stable(err_count) && $stable(first_fail_addr));
endmodule

// File: tb/addr_pattern_bist_test.sv
module addr_pattern_bist_test;
  localparam int AW = 16;
  localparam int EW = 3;
  localparam int SETTLE = 20;
  localparam logic [15:0] NONE = 16'hFFFF;

  // {size, fault1, fault2, expected errors, expected first fail}
  localparam logic [71:0] VEC [0:6] = '{
    {16'd64, NONE,   NONE,   8'd0, 16'd0},
    {16'd64, 16'd13, NONE,   8'd1, 16'd8},
    {16'd64, 16'd17, 16'd22, 8'd1, 16'd16},
    {16'd64, 16'd3,  16'd60, 8'd2, 16'd0},
    {16'd20, 16'd20, NONE,   8'd0, 16'd0},
    {16'd5,  NONE,   NONE,   8'd0, 16'd0},
    {16'd40, 16'd39, 16'd32, 8'd1, 16'd32}
  };

  logic clk = 0, rst_n = 0, start = 0;
  logic [AW-1:0] mem_size = '0;
  logic mem_req_valid, mem_req_write;
  logic [AW-1:0] mem_req_addr;
  logic [4:0] mem_req_len;
  logic [63:0] mem_wdata;
  logic mem_ack = 0;
  logic [31:0] mem_rdata = '0;
  logic done, pass;
  logic [EW-1:0] err_count;
  logic [AW-1:0] first_fail_addr;

  always #10 clk = ~clk;

  addr_pattern_bist #(.ADDR_W(AW), .ERR_W(EW), .RD_BYTES(4), .SETTLE_CYCLES(SETTLE)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .mem_size(mem_size),
    .mem_req_valid(mem_req_valid), .mem_req_write(mem_req_write),
    .mem_req_addr(mem_req_addr), .mem_req_len(mem_req_len), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata), .done(done), .pass(pass),
    .err_count(err_count), .first_fail_addr(first_fail_addr));

  int checks = 0, failures = 0;
  int mchecks = 0, mfails = 0;
  logic [7:0] mem [0:255];
  logic [15:0] f1 = NONE, f2 = NONE;
  bit all_bad = 0;
  int cyc = 0, last_wr = 0, wr_cnt = 0, rd_cnt = 0;
  bit seen_rd = 0;
  logic [AW-1:0] exp_wa = '0, exp_ra = '0;

  function automatic logic [63:0] exp_pat(input logic [AW-1:0] a);
    logic [31:0] w;
    w = 32'(a);
    return {~w, w};
  endfunction

  function automatic logic [7:0] rd_byte(input logic [AW-1:0] a);
    logic [7:0] b;
    b = mem[a[7:0]];
    if (all_bad || a == f1 || a == f2) b = b ^ 8'h01;
    return b;
  endfunction

  task automatic mchk(input bit ok, input string req, input longint act, input longint exp);
    mchecks++;
    if (!ok) begin
      mfails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // memory responder and bus monitor
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (mem_req_valid && !mem_ack) begin
      mem_ack <= 1'b1;
      if (mem_req_write) begin
        for (int i = 0; i < 8; i++) mem[8'(mem_req_addr + AW'(i))] <= mem_wdata[63-8*i -: 8];
      end else begin
        for (int i = 0; i < 4; i++) mem_rdata[31-8*i -: 8] <= rd_byte(mem_req_addr + AW'(i));
      end
    end else begin
      mem_ack <= 1'b0;
    end
    if (mem_req_valid && mem_ack) begin
      if (mem_req_write) begin
        mchk(!seen_rd, "R4 write after read", 1, 0);
        mchk(mem_req_addr == exp_wa, "R2 write addr", mem_req_addr, exp_wa);
        mchk(mem_req_len == 5'd8, "R2 write len", mem_req_len, 8);
        mchk(mem_wdata == exp_pat(mem_req_addr), "R2 write data", mem_wdata, exp_pat(mem_req_addr));
        exp_wa = exp_wa + 8;
        wr_cnt++;
        last_wr = cyc;
      end else begin
        if (!seen_rd && wr_cnt > 0)
          mchk(cyc - last_wr >= SETTLE, "R4 settle gap", cyc - last_wr, SETTLE);
        seen_rd = 1;
        mchk(mem_req_addr == exp_ra, "R5 read addr", mem_req_addr, exp_ra);
        mchk(mem_req_len == 5'd4, "R5 read len", mem_req_len, 4);
        exp_ra = exp_ra + 4;
        rd_cnt++;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic run(input logic [15:0] sz, input logic [15:0] a, input logic [15:0] b,
                     input bit bad, input bit extra_start);
    int n;
    @(negedge clk);
    f1 = a; f2 = b; all_bad = bad; mem_size = sz;
    seen_rd = 0; wr_cnt = 0; rd_cnt = 0; exp_wa = '0; exp_ra = '0;
    start = 1;
    @(negedge clk);
    start = 0;
    if (extra_start) begin
      repeat (6) @(negedge clk);
      start = 1;
      @(negedge clk);
      start = 0;
    end
    n = 0;
    while (!done && n < 5000) begin
      @(negedge clk);
      n++;
    end
    chk(done, "R11 run completion", done, 1);
  endtask

  initial begin
    #(20 * 190000);
    failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks + mchecks, failures + mfails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1
    chk(!done && !pass && err_count == 0 && first_fail_addr == 0 && !mem_req_valid,
        "R1 reset state", {done, pass, err_count, mem_req_valid}, 0);
    rst_n = 1;
    @(negedge clk);
    chk(!done && !mem_req_valid, "R1 after reset", {done, mem_req_valid}, 0);

    foreach (VEC[k]) begin
      logic [15:0] sz, ef;
      logic [7:0] ee;
      sz = VEC[k][71:56]; ee = VEC[k][23:16]; ef = VEC[k][15:0];
      run(sz, VEC[k][55:40], VEC[k][39:24], 0, 0);
      chk(err_count == EW'(ee), "R6 error count", err_count, ee);
      chk(pass == (ee == 0), "R8 pass flag", pass, ee == 0);
      chk(first_fail_addr == ef, "R9 first fail addr", first_fail_addr, ef);
      chk(wr_cnt == sz / 8, "R3 write block count", wr_cnt, sz / 8);
      chk(rd_cnt == 2 * (sz / 8), "R5 read burst count", rd_cnt, 2 * (sz / 8));
    end

    // R7: every block fails, counter stops at all-ones
    run(16'd128, NONE, NONE, 1, 0);
    chk(err_count == 3'd7, "R7 saturation", err_count, 7);
    chk(!pass, "R8 fail flag", pass, 0);
    chk(first_fail_addr == 0, "R9 first block", first_fail_addr, 0);

    // R11: restart from done clears results
    run(16'd64, NONE, NONE, 0, 0);
    chk(err_count == 0 && pass, "R11 restart clears", err_count, 0);

    // R11: start during a run is ignored
    run(16'd64, 16'd13, NONE, 0, 1);
    chk(wr_cnt == 8, "R11 extra start writes", wr_cnt, 8);
    chk(rd_cnt == 16, "R11 extra start reads", rd_cnt, 16);
    chk(err_count == 1 && first_fail_addr == 8, "R11 extra start result", err_count, 1);

    // R11: done holds while idle
    repeat (5) @(negedge clk);
    chk(done && err_count == 1, "R11 done holds", {done, err_count}, 4'h9);

    $display("TB_RESULT checks=%0d failures=%0d", checks + mchecks, failures + mfails);
    $finish;
  end
endmodule